// File: doc/BRIEF.md
# Ethernet Frame Statistics Counter Bank

This block holds the management statistics of an Ethernet MAC: 64 words of 32 bits each. The lower half belongs to the transmit side and the upper half to the receive side. When a frame finishes, the MAC pulses a frame-done strobe for one cycle. The strobe carries the frame length in bytes and a direction bit. In that same clock edge the block updates every counter the frame touches:

- the packet count and the frame-ok count each advance by one;
- the octet count and the good-octet count each grow by the length;
- exactly one frame-size histogram bin advances by one.

A host port gives access to every word by word index. Reads are combinational. Writes take effect at the next edge. Counters the block never updates, such as collision, CRC and drop counts, are plain storage that the host reads and writes.

Top module: `frame_stat_bank`

## Requirements
- R1: After reset every one of the 64 words reads as zero.
- R2: A frame event adds one to the packet word: index 1 for transmit (`evt_rx`=0), index 33 for receive (`evt_rx`=1).
- R3: A frame event adds `evt_len` to the octet word: index 17 for transmit, index 49 for receive.
- R4: A frame event adds one to the frame-ok word (index 19 for transmit, 51 for receive). It also adds `evt_len` to the good-octet word (index 29 for transmit, 56 for receive).
- R5: A frame event adds one to exactly one histogram word, chosen by length. Transmit uses 7 for lengths below 64, 10 for exactly 64, 11 for 65–127, 12 for 128–255, 13 for 256–511, 14 for 512–1023, 15 for 1024–2047 and 16 for 2048 or more. Receive uses the same bins at 39, 42, 43, 44, 45, 46, 47 and 48.
- R6: No word changes in a cycle without a host write to it or a frame event whose role list (R2–R5) names it.
- R7: `host_rdata` shows the current content of the word at `host_addr` in the same cycle.
- R8: A host write with `host_we`=1 stores `host_wdata` into word `host_addr`, and it is visible from the next cycle.
- R9: When a host write and a frame event hit the same word in one cycle, the word takes the host value. The event's other words still update.
- R10: Counters wrap modulo 2^32 and never saturate.
- R11: A transmit event never changes words 32–63, and a receive event never changes words 0–31. The half is given by the top bit of the word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | One-cycle frame-done strobe |
| evt_rx | input | 1 | Direction of the frame: 0 transmit, 1 receive |
| evt_len | input | LEN_W | Frame length in bytes |
| host_we | input | 1 | Host write enable |
| host_addr | input | AW | Host word index |
| host_wdata | input | CNT_W | Host write data |
| host_rdata | output | CNT_W | Word at `host_addr` |

## Verification
The checker watches a held host address and proves four things on every cycle:

- a host write lands and wins over a coinciding event;
- a quiet cycle leaves the word alone;
- an event steps the packet word by one and the octet word by the length;
- an event leaves the other direction's half untouched.

The choice of histogram bin at each edge, the frame-ok and good-octet pair, the wrap past 2^32 and the reset contents of all 64 words are shown only by the bench. The bench checks them through lengths placed on both sides of every bin edge, whole-bank sweeps and preloaded near-full words.

// File: rtl/frame_stat_bank.sv
module frame_stat_bank #(
  parameter int CNT_W = 32,
  parameter int WORDS = 64,
  parameter int LEN_W = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic             evt_rx,
  input  logic [LEN_W-1:0] evt_len,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic [CNT_W-1:0] host_wdata,
  output logic [CNT_W-1:0] host_rdata
);
  localparam int TX_PKT = 1,  TX_OCT = 17, TX_FOK = 19, TX_GOOD = 29, TX_FRAG = 7,  TX_H64 = 10;
  localparam int RX_PKT = 33, RX_OCT = 49, RX_FOK = 51, RX_GOOD = 56, RX_FRAG = 39, RX_H64 = 42;

  logic [CNT_W-1:0] cnt [WORDS];
  logic [2:0]       bin;
  logic [AW-1:0]    pkt_i, oct_i, fok_i, good_i, hist_i;
  logic [CNT_W-1:0] len_ext;

  always_comb begin
    if (evt_len < LEN_W'(64))          bin = 3'd0;
    else if (evt_len == LEN_W'(64))    bin = 3'd1;
    else if (evt_len < LEN_W'(128))    bin = 3'd2;
    else if (evt_len < LEN_W'(256))    bin = 3'd3;
    else if (evt_len < LEN_W'(512))    bin = 3'd4;
    else if (evt_len < LEN_W'(1024))   bin = 3'd5;
    else if (evt_len < LEN_W'(2048))   bin = 3'd6;
    else                               bin = 3'd7;
  end

  assign len_ext = CNT_W'(evt_len);
  assign pkt_i   = evt_rx ? AW'(RX_PKT)  : AW'(TX_PKT);
  assign oct_i   = evt_rx ? AW'(RX_OCT)  : AW'(TX_OCT);
  assign fok_i   = evt_rx ? AW'(RX_FOK)  : AW'(TX_FOK);
  assign good_i  = evt_rx ? AW'(RX_GOOD) : AW'(TX_GOOD);
  assign hist_i  = (bin == 3'd0) ? (evt_rx ? AW'(RX_FRAG) : AW'(TX_FRAG))
                                 : (evt_rx ? AW'(RX_H64)  : AW'(TX_H64)) + AW'(bin) - AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (host_we && host_addr == AW'(i))
          cnt[i] <= host_wdata;
        else if (evt_valid) begin
          if (AW'(i) == pkt_i || AW'(i) == fok_i || AW'(i) == hist_i)
            cnt[i] <= cnt[i] + CNT_W'(1);
          else if (AW'(i) == oct_i || AW'(i) == good_i)
            cnt[i] <= cnt[i] + len_ext;
        end
      end
    end
  end

  assign host_rdata = cnt[host_addr];
endmodule

// File: rtl/frame_stat_bank_chk.sv
module frame_stat_bank_chk #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 16,
  parameter int AW = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_valid,
  input logic             evt_rx,
  input logic [LEN_W-1:0] evt_len,
  input logic             host_we,
  input logic [AW-1:0]    host_addr,
  input logic [CNT_W-1:0] host_wdata,
  input logic [CNT_W-1:0] host_rdata
);
  AST_HOST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |=> (host_addr != $past(host_addr)) || (host_rdata == $past(host_wdata))); // R8
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && !host_we) |=> (host_addr != $past(host_addr)) || $stable(host_rdata)); // R6
  AST_PKT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !host_we && host_addr == (evt_rx ? AW'(33) : AW'(1)))
    |=> (host_addr != $past(host_addr)) || (host_rdata == CNT_W'($past(host_rdata) + CNT_W'(1)))); // R2
  AST_OCT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !host_we && host_addr == (evt_rx ? AW'(49) : AW'(17)))
    |=> (host_addr != $past(host_addr)) ||
        (host_rdata == CNT_W'($past(host_rdata) + CNT_W'($past(evt_len))))); // R3
  AST_OTHER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !host_we && host_addr[AW-1] != evt_rx)
    |=> (host_addr != $past(host_addr)) || $stable(host_rdata)); // R11
endmodule

bind frame_stat_bank frame_stat_bank_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_rx(evt_rx), .evt_len(evt_len),
  .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
);

// File: tb/tb_frame_stat_bank.sv
module tb_frame_stat_bank;
  logic        clk = 0, rst_n = 0;
  logic        evt_valid = 0, evt_rx = 0, host_we = 0;
  logic [15:0] evt_len = '0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  int unsigned mdl [64];
  int vectors = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  frame_stat_bank dut (.clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_rx(evt_rx),
    .evt_len(evt_len), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata));

  function automatic int bin_of(input int len, input bit rx);
    int b;
    if (len < 64) return rx ? 39 : 7;
    else if (len == 64) b = 0;
    else if (len < 128) b = 1;
    else if (len < 256) b = 2;
    else if (len < 512) b = 3;
    else if (len < 1024) b = 4;
    else if (len < 2048) b = 5;
    else b = 6;
    return (rx ? 42 : 10) + b;
  endfunction

  task automatic step(input bit we, input int a, input int unsigned wd,
                      input bit ev, input bit rx, input int len, input string tag);
    host_we = we; host_addr = 6'(a); host_wdata = wd;
    evt_valid = ev; evt_rx = rx; evt_len = 16'(len);
    #1;
    vectors++;
    if (host_rdata !== mdl[a]) begin
      fails++;
      $display("FAIL %s word %0d got %h exp %h", tag, a, host_rdata, mdl[a]);
    end
    @(posedge clk);
    if (ev) begin
      mdl[rx ? 33 : 1]  += 1;
      mdl[rx ? 49 : 17] += len;
      mdl[rx ? 51 : 19] += 1;
      mdl[rx ? 56 : 29] += len;
      mdl[bin_of(len, rx)] += 1;
    end
    if (we) mdl[a] = wd;
    @(negedge clk);
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 64; a++) step(0, a, 0, 0, 0, 0, tag);
  endtask

  initial begin
    int lens [14] = '{10, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 2047, 2048};
    for (int i = 0; i < 64; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    sweep("R1");
    foreach (lens[k]) step(0, 1, 0, 1, 0, lens[k], "R2 tx");
    step(0, 17, 0, 1, 0, 9000, "R3 tx");
    sweep("R4 R5 R6 R11 tx");
    foreach (lens[k]) step(0, 49, 0, 1, 1, lens[k], "R3 rx");
    step(0, 33, 0, 1, 1, 60000, "R2 rx");
    sweep("R4 R5 R6 R11 rx");
    step(1, 5, 32'hA5A5_0001, 0, 0, 0, "R8");
    step(1, 60, 32'h1234_5678, 0, 0, 0, "R8");
    step(0, 5, 0, 0, 0, 0, "R7");
    step(0, 60, 0, 0, 0, 0, "R7");
    step(1, 33, 32'h0000_0100, 1, 1, 300, "R9");
    step(0, 33, 0, 0, 0, 0, "R9");
    step(0, 45, 0, 0, 0, 0, "R9 other words");
    step(1, 1, 32'hFFFF_FFFF, 0, 0, 0, "R10");
    step(1, 17, 32'hFFFF_FFF0, 0, 0, 0, "R10");
    step(0, 1, 0, 1, 0, 100, "R10");
    step(0, 1, 0, 0, 0, 0, "R10");
    step(0, 17, 0, 0, 0, 0, "R10");
    sweep("R6 final");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule